// File: doc/BRIEF.md
# MII Management Frame Master

This block drives the two-wire PHY management bus. Software sets a PHY address, a register address, write data, a clock divisor and a preamble-skip bit through a small write-only register port, then writes an opcode. The block generates MDC from the bus clock and shifts out one management frame. For a write it drives MDIO for the whole frame. For a read it releases MDIO after the register address and captures the 16 data bits the PHY returns.

While a frame is in progress the block reports busy, and it ignores all setup and opcode writes. When the last bit completes, MDC returns low, busy drops and a sticky completion flag rises. Software clears that flag by writing 1 to it. The MDIO pad is modelled as a separate output, output enable and input.

Register port: address 0 holds the PHY address in bits [4:0] and the register address in bits [12:8]. Address 1 holds the write data. Address 2 holds the divisor in bits [DIV_W-1:0] and the preamble-skip bit in bit 15. Address 3 is the command register: bits [1:0] are the opcode and bit 8 is the flag clear.

Top module: `mdio_master`

## Requirements
- R1: After reset busy_o, done_o, mdc_o, mdio_oe_o and rd_data_o are all 0.
- R2: A command write with opcode 01 starts a write frame and opcode 10 starts a read frame. busy_o is high from the next clock. Opcodes 00 and 11 start nothing.
- R3: When the divisor is 0, no frame starts, busy_o stays low and MDC stays low.
- R4: Each MDC half-period lasts exactly divisor bus clocks, starting with a low phase. A frame of N bits keeps busy_o high for N*2*divisor clocks and makes N rising edges. MDC is low whenever busy_o is low.
- R5: With CFG bit 15 clear, 32 ones precede the start field (64 bits per frame). With it set, the frame begins at the start field (32 bits per frame).
- R6: After the preamble the frame carries start 01, the opcode, the 5-bit PHY address and the 5-bit register address, each MSB first. A write frame then carries turnaround 1,0 and the 16 data bits MSB first.
- R7: In a read frame mdio_oe_o is low for the two turnaround bits and the 16 data bits. mdio_i is sampled on each MDC rising edge during the data bits, and rd_data_o takes the 16 bits (first bit as MSB) at frame end. A write frame leaves rd_data_o unchanged.
- R8: On the clock edge where the last bit ends, MDC goes low, busy_o falls and done_o rises together.
- R9: Writing the command register with bit 8 set clears done_o. A command write with bit 8 clear leaves done_o unchanged.
- R10: Writes to the address, data, divisor/preamble and opcode fields while busy_o is high are discarded. The frame in flight is unaffected, no new frame follows, and later frames use the earlier settings.
- R11: MDIO changes only when MDC falls, so it is stable across every MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select (0 addr, 1 wdata, 2 cfg, 3 cmd) |
| reg_wdata_i | input | 16 | Register write data |
| mdio_i | input | 1 | MDIO pad input |
| rd_data_o | output | 16 | Data from the last read frame |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Completion flag, cleared by writing 1 to it |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe_o | output | 1 | MDIO pad output enable |

## Verification
Frames are run as writes and reads, with and without preamble, at divisors from 1 to 6. Random PHY addresses, register addresses and data expose any misordered field or shift error. Mixing the two frame types and both preamble settings separates the drive-enable pattern, the frame length and the capture point, since each depends on a different input. The directed cases cover opcodes 00 and 11, a zero divisor, and a burst of configuration and command writes during a frame. A later frame with no reconfiguration then tells a discarded write apart from one that was merely delayed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW   = 5;
  localparam int REG_AW   = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_LEN  = 32;
  localparam int TA_LEN   = 2;
  localparam int HDR_LEN  = 2 + 2 + PHY_AW + REG_AW;
  localparam int BODY_LEN = HDR_LEN + TA_LEN + DATA_W;
  localparam int FULL_LEN = PRE_LEN + BODY_LEN;

  localparam int REG_AD_LSB    = 8;
  localparam int CFG_NOPRE_BIT = 15;
  localparam int CMD_CLR_BIT   = 8;

  typedef enum logic [1:0] {
    OPC_NOP_LO = 2'b00,
    OPC_WRITE  = 2'b01,
    OPC_READ   = 2'b10,
    OPC_NOP_HI = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    RA_ADDR  = 2'd0,
    RA_WDATA = 2'd1,
    RA_CFG   = 2'd2,
    RA_CMD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_set_i,
  output logic [PHY_AW-1:0] phy_o,
  output logic [REG_AW-1:0] reg_ad_o,
  output logic [DATA_W-1:0] wd_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              nopre_o,
  output logic              start_o,
  output opc_e              op_o,
  output logic              done_o
);
  reg_addr_e ra;
  logic      setup_we;
  logic      clr_req;

  assign ra       = reg_addr_e'(addr_i);
  assign op_o     = opc_e'(wdata_i[1:0]);
  assign setup_we = we_i && !busy_i;
  assign clr_req  = we_i && (ra == RA_CMD) && wdata_i[CMD_CLR_BIT];
  assign start_o  = setup_we && (ra == RA_CMD) &&
                    ((op_o == OPC_WRITE) || (op_o == OPC_READ)) && (div_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_o    <= '0;
      reg_ad_o <= '0;
      wd_o     <= '0;
      div_o    <= '0;
      nopre_o  <= 1'b0;
    end else if (setup_we) begin
      case (ra)
        RA_ADDR: begin
          phy_o    <= wdata_i[PHY_AW-1:0];
          reg_ad_o <= wdata_i[REG_AD_LSB +: REG_AW];
        end
        RA_WDATA: wd_o <= wdata_i;
        RA_CFG: begin
          div_o   <= wdata_i[DIV_W-1:0];
          nopre_o <= wdata_i[CFG_NOPRE_BIT];
        end
        default: ;
      endcase
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_o <= 1'b0;
    else if (done_set_i) done_o <= 1'b1;
    else if (clr_req)    done_o <= 1'b0;
  end

  assert_cfg_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(div_o) && $stable(nopre_o) &&
                                   $stable(wd_o) && $stable(phy_o)));

  assert_div_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (div_o != '0));
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == div_i - DIV_W'(1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assert_mdc_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mdc_q);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  opc_e              op_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [REG_AW-1:0] reg_ad_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              nopre_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_set_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int SH_W    = FULL_LEN;
  localparam int CNT_W   = $clog2(SH_W + 1);
  localparam int RLS_LEN = TA_LEN + DATA_W;

  logic [SH_W-1:0]     sh_q;
  logic [CNT_W-1:0]    left_q;
  logic                busy_q, rd_q;
  logic [DATA_W-1:0]   cap_q, rd_data_q;
  logic [BODY_LEN-1:0] body;
  logic                is_wr;

  assign is_wr = (op_i == OPC_WRITE);

  always_comb begin
    body = {2'b01, op_i, phy_i, reg_ad_i,
            is_wr ? 2'b10 : 2'b11,
            is_wr ? wd_i : {DATA_W{1'b1}}};
  end

  assign done_set_o = busy_q && fall_i && (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rd_q      <= 1'b0;
      sh_q      <= '0;
      left_q    <= '0;
      cap_q     <= '0;
      rd_data_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rd_q   <= (op_i == OPC_READ);
      cap_q  <= '0;
      if (nopre_i) begin
        sh_q   <= {body, {PRE_LEN{1'b1}}};
        left_q <= CNT_W'(BODY_LEN);
      end else begin
        sh_q   <= {{PRE_LEN{1'b1}}, body};
        left_q <= CNT_W'(FULL_LEN);
      end
    end else if (busy_q) begin
      if (rise_i && rd_q && (left_q <= CNT_W'(DATA_W)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          if (rd_q) rd_data_q <= cap_q;
        end else begin
          sh_q   <= {sh_q[SH_W-2:0], 1'b0};
          left_q <= left_q - CNT_W'(1);
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = busy_q & sh_q[SH_W-1];
  assign mdio_oe_o = busy_q && (!rd_q || (left_q > CNT_W'(RLS_LEN)));
  assign rd_data_o = rd_data_q;

  assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);

  assert_mdio_stable_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  input  logic        mdio_i,
  output logic [15:0] rd_data_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [PHY_AW-1:0] phy;
  logic [REG_AW-1:0] reg_ad;
  logic [DATA_W-1:0] wd;
  logic [DIV_W-1:0]  div;
  logic              nopre, start, done_set, rise, fall, busy;
  opc_e              op;

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .done_set_i (done_set),
    .phy_o      (phy),
    .reg_ad_o   (reg_ad),
    .wd_o       (wd),
    .div_o      (div),
    .nopre_o    (nopre),
    .start_o    (start),
    .op_o       (op),
    .done_o     (done_o)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .op_i       (op),
    .phy_i      (phy),
    .reg_ad_i   (reg_ad),
    .wd_i       (wd),
    .nopre_i    (nopre),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .busy_o     (busy),
    .done_set_o (done_set),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rd_data_o  (rd_data_o)
  );

  assign busy_o = busy;

  assert_done_on_finish_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (done_o && !mdc_o));
endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  localparam logic [1:0] A_ADDR = 2'd0, A_WDATA = 2'd1, A_CFG = 2'd2, A_CMD = 2'd3;
  localparam logic [1:0] OP_WR = 2'b01, OP_RD = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic mdio_in = 1'b1;
  logic [15:0] rd_data;
  logic busy, done, mdc, mdio_out, mdio_oe;

  int checks = 0, errors = 0;
  bit finished = 0;
  int n_exp = 64, rise_cnt = 0;
  logic [15:0] phy_val = '0, exp_rd = '0;
  logic [63:0] cap_val = '0, cap_oe = '0;

  always #2.5 clk = ~clk;

  mdio_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .mdio_i(mdio_in), .rd_data_o(rd_data), .busy_o(busy),
    .done_o(done), .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  // PHY model: record each MDC rising edge, answer reads after falling edges
  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap_val[63-rise_cnt] = mdio_out;
      cap_oe[63-rise_cnt]  = mdio_oe;
    end
    rise_cnt++;
  end

  always @(negedge mdc) begin
    int k;
    k = rise_cnt - (n_exp - 16);
    if (k >= 0 && k < 16) mdio_in = phy_val[15-k];
  end

  function automatic logic [63:0] exp_frame(logic [1:0] op, logic [4:0] phy, logic [4:0] rg,
                                             logic [15:0] wd, bit np);
    logic [31:0] body;
    body = {2'b01, op, phy, rg, (op == OP_WR) ? 2'b10 : 2'b11, (op == OP_WR) ? wd : 16'hFFFF};
    return np ? {body, 32'h0} : {32'hFFFF_FFFF, body};
  endfunction

  function automatic logic [63:0] mask_top(int k);
    return (k == 0) ? 64'h0 : (~64'h0 << (64 - k));
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(logic [4:0] phy, logic [4:0] rg, logic [15:0] wd, int dv, bit np);
    wr(A_ADDR, {3'b0, rg, 3'b0, phy});
    wr(A_WDATA, wd);
    wr(A_CFG, {np, 7'b0, 8'(dv)});
  endtask

  task automatic run_frame(logic [1:0] op, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                           int dv, bit np, logic [15:0] rv, bit junk);
    int n, cycles, hi, chg;
    logic prev_mdio;
    logic [63:0] ef, drv;
    n = np ? 32 : 64;
    n_exp = n; phy_val = rv; rise_cnt = 0; cap_val = '0; cap_oe = '0; mdio_in = 1'b1;
    wr(A_CMD, {14'b0, op});
    chk(busy == 1'b1, "R2 busy after opcode", 64'(busy), 64'd1);
    cycles = 0; hi = 0; chg = 0; prev_mdio = mdio_out;
    while (busy && cycles < 20000) begin
      cycles++;
      if (mdc) hi++;
      if (mdc && mdio_out != prev_mdio) chg++;
      prev_mdio = mdio_out;
      if (junk) begin
        case (cycles)
          5: begin reg_we = 1'b1; reg_addr = A_ADDR;  reg_wdata = 16'h1F1F; end
          6: begin reg_addr = A_WDATA; reg_wdata = ~wd; end
          7: begin reg_addr = A_CFG;   reg_wdata = {~np, 15'd1}; end
          8: begin reg_addr = A_CMD;   reg_wdata = 16'h0002; end
          9: reg_we = 1'b0;
          default: ;
        endcase
      end
      @(negedge clk);
    end
    ef  = exp_frame(op, phy, rg, wd, np);
    drv = mask_top((op == OP_RD) ? n - 18 : n);
    chk(cycles == n * 2 * dv, "R4 busy length", 64'(cycles), 64'(n * 2 * dv));
    chk(hi == n * dv, "R4 mdc high time", 64'(hi), 64'(n * dv));
    chk(rise_cnt == n, "R4 R5 mdc rising edges", 64'(rise_cnt), 64'(n));
    chk((cap_val & drv) == (ef & drv), "R5 R6 driven frame bits", cap_val & drv, ef & drv);
    chk(cap_oe == drv, "R7 output enable pattern", cap_oe, drv);
    chk(chg == 0, "R11 mdio change while mdc high", 64'(chg), 64'd0);
    chk(done && !mdc && !busy, "R8 completion state", {61'd0, done, mdc, busy}, 64'h4);
    if (op == OP_RD) exp_rd = rv;
    chk(rd_data == exp_rd, "R7 read data", 64'(rd_data), 64'(exp_rd));
  endtask

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe && rd_data == 16'h0, "R1 reset state",
        {43'd0, rd_data, busy, done, mdc, mdio_oe, 1'b0}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // divisor zero blocks
    setup(5'h03, 5'h01, 16'hA5A5, 0, 1'b0);
    rise_cnt = 0;
    wr(A_CMD, {14'b0, OP_WR});
    repeat (10) @(negedge clk);
    chk(!busy && !mdc && rise_cnt == 0, "R3 zero divisor blocks frame",
        {62'd0, busy, mdc}, 64'h0);

    // directed frames
    setup(5'h15, 5'h0A, 16'hC3E1, 2, 1'b0);
    run_frame(OP_WR, 5'h15, 5'h0A, 16'hC3E1, 2, 1'b0, 16'h0, 1'b0);
    wr(A_CMD, 16'h0000);
    chk(done == 1'b1, "R9 write without clear bit keeps flag", 64'(done), 64'd1);
    wr(A_CMD, 16'h0100);
    chk(done == 1'b0, "R9 flag cleared by writing 1", 64'(done), 64'd0);

    setup(5'h01, 5'h1F, 16'h0000, 1, 1'b0);
    run_frame(OP_RD, 5'h01, 5'h1F, 16'h0000, 1, 1'b0, 16'hB26D, 1'b0);
    wr(A_CMD, 16'h0100);
    setup(5'h1E, 5'h05, 16'h8001, 3, 1'b1);
    run_frame(OP_WR, 5'h1E, 5'h05, 16'h8001, 3, 1'b1, 16'h0, 1'b0);
    wr(A_CMD, 16'h0100);
    setup(5'h00, 5'h10, 16'h1234, 5, 1'b1);
    run_frame(OP_RD, 5'h00, 5'h10, 16'h1234, 5, 1'b1, 16'h4F1C, 1'b0);
    wr(A_CMD, 16'h0100);

    // non-starting opcodes
    rise_cnt = 0;
    wr(A_CMD, 16'h0000);
    repeat (8) @(negedge clk);
    chk(!busy && rise_cnt == 0, "R2 opcode 00 starts nothing", 64'(busy), 64'd0);
    wr(A_CMD, 16'h0003);
    repeat (8) @(negedge clk);
    chk(!busy && rise_cnt == 0 && !mdc, "R2 opcode 11 starts nothing", 64'(busy), 64'd0);

    // writes while busy are discarded
    setup(5'h0C, 5'h13, 16'h5AF0, 3, 1'b0);
    run_frame(OP_WR, 5'h0C, 5'h13, 16'h5AF0, 3, 1'b0, 16'h0, 1'b1);
    rise_cnt = 0;
    repeat (20) @(negedge clk);
    chk(!busy && rise_cnt == 0, "R10 opcode written while busy starts nothing",
        64'(busy), 64'd0);
    wr(A_CMD, 16'h0100);
    run_frame(OP_WR, 5'h0C, 5'h13, 16'h5AF0, 3, 1'b0, 16'h0, 1'b0);
    chk(1'b1, "R10 earlier settings kept (checked by frame above)", 64'd0, 64'd0);
    wr(A_CMD, 16'h0100);

    // random frames
    for (int i = 0; i < 12; i++) begin
      logic [1:0] op;
      logic [4:0] phy, rg;
      logic [15:0] wd, rv;
      int dv;
      bit np;
      op  = ($urandom % 2) ? OP_WR : OP_RD;
      phy = 5'($urandom); rg = 5'($urandom);
      wd  = 16'($urandom); rv = 16'($urandom);
      dv  = 1 + ($urandom % 6);
      np  = 1'($urandom);
      setup(phy, rg, wd, dv, np);
      run_frame(op, phy, rg, wd, dv, np, rv, 1'($urandom % 4 == 0));
      wr(A_CMD, 16'h0100);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 act=hung exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule